// File: doc/BRIEF.md
# Millisecond Interval Timer

This block raises a periodic interrupt at a programmable whole-millisecond interval. A prescaler divides the system clock down to one pulse per millisecond, using the parameter `CYCLES_PER_MS`. A millisecond counter then counts those pulses up to a 32-bit reload value. The interval is therefore `reload + 1` milliseconds. When an interval ends, the interrupt line goes high. The next interval starts on its own with the same reload value, so software only has to acknowledge each interrupt.

Software uses two word registers:
- Writing the reload register stores a new value, clears any pending interrupt and starts a fresh interval from zero.
- Reading the count register returns zero and clears the interrupt.

After reset the timer stays idle until the first write to the reload register.

Top module: `ms_interval_timer`

## Requirements
- R1: After reset, `tick_irq` is 0 and a read of the reload register returns 0. Until the first reload write, no interrupt is raised however long the clock runs.
- R2: A reload write at clock edge E0 with value R sets `tick_irq` at edge E0 + (R+1)·CYCLES_PER_MS, and not before.
- R3: Each expiry starts the next interval by itself with the current reload value. With the interrupt acknowledged in between, consecutive rises are (R+1)·CYCLES_PER_MS edges apart.
- R4: A reload write clears a pending interrupt at the edge that samples it. It also restarts the interval from zero, whatever part of the old interval had passed.
- R5: A read of the count register (byte address 0x230, decoded on bits [11:2]) returns 0 in the same cycle and clears `tick_irq` at the next edge. It does not change the interval in progress.
- R6: If a count-register read and an expiry happen in the same cycle, the expiry wins and `tick_irq` stays 1.
- R7: The reload register sits at byte address 0x228, decoded on bits [11:2]. A read of it returns the stored value. A write to any other address is ignored and does not shift the interval in progress.
- R8: Reload value 0 gives an interval of exactly CYCLES_PER_MS clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe, one cycle per access |
| rd_en | input | 1 | Register read strobe, one cycle per access |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the cycle `rd_en` is high |
| tick_irq | output | 1 | Level interrupt, high once an interval has expired and not yet been acknowledged |

## Verification
The bench uses directed tests with a small prescaler so that every interval can be counted edge by edge.
- Reload values 0, 1, 2 and 3 are tried. A mistake in the "+1" or in the prescaler scaling then shows up as a different rise cycle for each value.
- Repeated intervals with an acknowledge between them separate automatic re-arming from one-shot behaviour.
- A restart in mid-interval separates a counter that is cleared from one that keeps running.
- A count read placed exactly on the expiry cycle, and a write to the wrong address during an interval, show which event wins a collision and that a foreign access leaves the interval alone.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
  // Result of register address decode
  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_RELOAD = 2'd1,
    ACC_COUNT  = 2'd2
  } acc_e;
endpackage

// File: rtl/tmr_reg_if.sv
module tmr_reg_if
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] RELOAD_ADDR = 12'h228,
  parameter logic [ADDR_W-1:0] COUNT_ADDR  = 12'h230
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  word_t             wdata,
  output word_t             rd_data,
  output word_t             reload,
  output logic              armed,
  output logic              restart,
  output logic              ack
);
  localparam int unsigned WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] RELOAD_WA = RELOAD_ADDR[ADDR_W-1:2];
  localparam logic [WA_W-1:0] COUNT_WA  = COUNT_ADDR[ADDR_W-1:2];

  acc_e  acc;
  word_t reload_q, reload_d;
  logic  armed_q, armed_d;
  logic  reload_en;

  // word decode, byte lanes ignored
  always_comb begin
    if (addr[ADDR_W-1:2] == RELOAD_WA)     acc = ACC_RELOAD;
    else if (addr[ADDR_W-1:2] == COUNT_WA) acc = ACC_COUNT;
    else                                   acc = ACC_NONE;
  end

  always_comb begin
    reload_en = wr_en && (acc == ACC_RELOAD);
    restart   = reload_en;
    ack       = reload_en || (rd_en && (acc == ACC_COUNT));
    reload_d  = reload_en ? wdata : reload_q;
    armed_d   = armed_q || reload_en;
    rd_data   = '0;
    if (rd_en && (acc == ACC_RELOAD)) rd_data = reload_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      armed_q  <= 1'b0;
    end else begin
      if (reload_en) reload_q <= reload_d;
      armed_q <= armed_d;
    end
  end

  assign reload = reload_q;
  assign armed  = armed_q;

  AST_RELOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (acc == ACC_RELOAD)) |=> $stable(reload_q)) else $error("reload changed without write"); // R7
  AST_COUNT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (acc == ACC_COUNT)) |-> (rd_data == '0)) else $error("count read nonzero"); // R5
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned CYCLES_PER_MS = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic ms_tick
);
  generate
    if (CYCLES_PER_MS <= 1) begin : g_direct
      assign ms_tick = run && !clear;
    end else begin : g_count
      localparam int unsigned PRE_W = $clog2(CYCLES_PER_MS);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYCLES_PER_MS - 1);

      logic [PRE_W-1:0] pre_q, pre_d;
      logic             pre_en;
      logic             wrap;

      always_comb begin
        wrap    = (pre_q == PRE_LAST);
        ms_tick = run && !clear && wrap;
        pre_en  = clear || run;
        if (clear || wrap) pre_d = '0;
        else               pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (pre_en) pre_q <= pre_d;
      end

      AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_LAST) else $error("prescaler out of range"); // R2
      AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(pre_q)) else $error("prescaler ran while idle"); // R1
    end
  endgenerate
endmodule

// File: rtl/tmr_ms_counter.sv
module tmr_ms_counter
  import tmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ms_tick,
  input  logic  clear,
  input  word_t reload,
  output logic  expire
);
  word_t ms_q, ms_d;
  logic  ms_en;
  logic  at_end;

  always_comb begin
    at_end = (ms_q == reload);
    expire = ms_tick && at_end;
    ms_en  = clear || ms_tick;
    if (clear || at_end) ms_d = '0;
    else                 ms_d = ms_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ms_q <= '0;
    else if (ms_en) ms_q <= ms_d;
  end

  AST_MS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q <= reload) else $error("ms count beyond reload"); // R3
  AST_MS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (ms_q == '0)) else $error("restart did not zero count"); // R4
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ack,
  output logic irq
);
  logic irq_q, irq_d;

  // expiry has priority over acknowledge
  always_comb begin
    if (expire)   irq_d = 1'b1;
    else if (ack) irq_d = 1'b0;
    else          irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq_q) else $error("expiry lost"); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !expire) |=> !irq_q) else $error("ack ignored"); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(expire)) else $error("irq without expiry"); // R2
endmodule

// File: rtl/ms_interval_timer.sv
module ms_interval_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CYCLES_PER_MS = 125000,
  parameter int unsigned ADDR_W        = 12,
  parameter logic [ADDR_W-1:0] RELOAD_ADDR = 12'h228,
  parameter logic [ADDR_W-1:0] COUNT_ADDR  = 12'h230
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rd_data,
  output logic              tick_irq
);
  word_t reload;
  logic  armed, restart, ack, ms_tick, expire;

  tmr_reg_if #(
    .ADDR_W(ADDR_W), .RELOAD_ADDR(RELOAD_ADDR), .COUNT_ADDR(COUNT_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .reload(reload), .armed(armed),
    .restart(restart), .ack(ack)
  );

  tmr_prescaler #(.CYCLES_PER_MS(CYCLES_PER_MS)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(armed), .clear(restart), .ms_tick(ms_tick)
  );

  tmr_ms_counter u_ms (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .clear(restart),
    .reload(reload), .expire(expire)
  );

  tmr_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .ack(ack), .irq(tick_irq)
  );

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !ms_tick) else $error("tick before first reload write"); // R1
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick_irq) else $error("reload write left irq set"); // R4
endmodule

// File: tb/tb_ms_interval_timer.sv
`timescale 1ns/1ps
module tb_ms_interval_timer;
  localparam int CPM = 6;
  localparam logic [11:0] A_RELOAD = 12'h228;
  localparam logic [11:0] A_COUNT  = 12'h230;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [11:0] addr;
  logic [31:0] wdata, rd_data;
  logic        tick_irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ms_interval_timer #(.CYCLES_PER_MS(CPM)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .tick_irq(tick_irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rd_data;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  // number of edges until tick_irq is first seen high (0 = never)
  task automatic edges_to_rise(input int lim, output int got);
    got = 0;
    for (int k = 1; k <= lim && got == 0; k++) begin
      @(posedge clk); @(negedge clk);
      if (tick_irq) got = k;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d; int got;
    chk(tick_irq == 1'b0, "R1 irq after reset", tick_irq, 0);
    do_rd(A_RELOAD, d);
    chk(d == 32'd0, "R1 reload after reset", d, 0);
    edges_to_rise(5 * CPM, got);
    chk(got == 0, "R1 idle before first write", got, 0);
  endtask

  task automatic t_period(input int r);
    int got; logic [31:0] d;
    do_wr(A_RELOAD, r);
    edges_to_rise(4 * (r + 1) * CPM, got);
    chk(got == (r + 1) * CPM, "R2 first interval", got, (r + 1) * CPM);
    do_rd(A_COUNT, d);
    chk(tick_irq == 1'b0, "R5 read acks irq", tick_irq, 0);
  endtask

  task automatic t_rearm(input int r, input string req);
    int got; logic [31:0] d;
    int p = (r + 1) * CPM;
    do_wr(A_RELOAD, r);
    edges_to_rise(4 * p, got);
    chk(got == p, req, got, p);
    for (int n = 0; n < 3; n++) begin
      do_rd(A_COUNT, d);
      chk(d == 32'd0, "R5 count read value", d, 0);
      edges_to_rise(4 * p, got);
      chk(got == p - 1, "R3 auto re-arm spacing", got, p - 1);
    end
    do_rd(A_COUNT, d);
  endtask

  task automatic t_restart;
    int got;
    do_wr(A_RELOAD, 1);
    edges_to_rise(8 * CPM, got);
    chk(got == 2 * CPM, "R4 pre-restart interval", got, 2 * CPM);
    do_wr(A_RELOAD, 3);
    chk(tick_irq == 1'b0, "R4 write clears pending irq", tick_irq, 1'b0);
    idle(CPM + 2);
    do_wr(A_RELOAD, 2);
    edges_to_rise(8 * CPM, got);
    chk(got == 3 * CPM, "R4 mid-interval restart", got, 3 * CPM);
  endtask

  task automatic t_collision;
    logic [31:0] d; int p = 2 * CPM;
    do_wr(A_RELOAD, 1);
    idle(p - 1);
    chk(tick_irq == 1'b0, "R6 low before expiry", tick_irq, 0);
    do_rd(A_COUNT, d);   // sampled at the expiry edge
    chk(tick_irq == 1'b1, "R6 expiry beats read ack", tick_irq, 1);
    do_rd(A_COUNT, d);
    chk(tick_irq == 1'b0, "R5 later read acks", tick_irq, 0);
  endtask

  task automatic t_foreign;
    logic [31:0] d; int got; int p = 3 * CPM;
    do_wr(A_RELOAD, 2);
    idle(5);
    do_wr(A_COUNT, 32'd0);
    do_wr(12'h22C, 32'd9);
    do_rd(A_RELOAD, d);
    chk(d == 32'd2, "R7 reload readback", d, 2);
    edges_to_rise(4 * p, got);
    chk(got == p - 8, "R7 foreign write ignored", got, p - 8);
    do_rd(A_COUNT, d);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_period(2);
    t_period(0);
    t_rearm(1, "R3 first interval");
    t_rearm(0, "R8 reload zero interval");
    t_restart();
    t_collision();
    t_foreign();
    finish_run();
  end
endmodule